// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Engine

This block is a bus-master DMA engine for one disk-interface channel. Software programs it through a bank of 32-bit registers spaced four bytes apart. It writes the address of a descriptor list and the address of a completion area, then writes the control word with the direction and the start bit set. The engine reads descriptors from memory one after another. Each descriptor names a buffer and a length. The engine moves the buffer as 32-bit beats between a streaming device port and a simple request/acknowledge memory port.

The engine keeps two byte counters, one for the device side and one for the memory side, and software can read both. After the last data beat of the final descriptor, the engine writes all-ones words across the completion area. Software zeroes that area before a transfer and polls it afterwards. In this way software does not depend on a register read that could overtake earlier data writes. A halt is requested through a stop bit. That bit stays set until the engine has actually come to rest. A memory error response aborts the transfer and leaves an error flag behind.

Top module: `sgdma_ctrl`

## Requirements
- R1: Register word indexes 0 (timing), 1 (list pointer low), 2 (list pointer high), 4 (address high) and 8 (completion-area address) read back the value last written. Index 3 returns the current buffer address and ignores writes. Indexes 5 (device byte count) and 6 (memory byte count) are read-only. All other indexes read 0.
- R2: The control/status word sits at index 7. Bit 0 is start: writing 1 while idle begins a transfer, and the bit always reads 0. Bit 1 is the stop request, bit 2 is direction, bit 3 is active and bit 4 is error. All other bits read 0.
- R3: A write of the control word while active is set leaves direction, active and both counters unchanged. Only its stop bit takes effect.
- R4: A descriptor is 16 bytes and is read as four 32-bit bus words at pointer +0, +4, +8 and +12. Each word is big-endian: bus bits 7:0 carry its most significant byte. Word 1 is the buffer address. In word 3, bit 31 marks end-of-list and bits LEN_W-1:0 give the byte length. The next descriptor follows at +16.
- R5: With direction 1, each beat taken from the device port is written to memory at consecutive word addresses, starting at the buffer address.
- R6: With direction 0, words are read from consecutive addresses, starting at the buffer address, and are handed to the device port in order.
- R7: A length field of 0 stands for 2^LEN_W bytes (65536 by default).
- R8: Both counters clear at start. Each beat adds 4 bytes, or the remainder on a short final beat. The two counters never differ by more than 4, and they are equal when the completion writes begin.
- R9: After the last data access of the end-of-list descriptor, the engine writes COMPL_BYTES/4 all-ones words to consecutive addresses from the completion address. No data write follows them. Active then clears.
- R10: After a stop request, the stop bit reads 1 until the engine has halted. The engine completes any outstanding memory access and then issues no further request. Active and stop then clear, and no completion write is made.
- R11: A memory error response sets the error bit and clears active. No further request is issued. The error bit stays set until a stop request completes.
- R12: A memory request holds its address, write flag and data until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request acknowledged |
| mem_err | input | 1 | Error response, valid with mem_ack |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| dev_rx_valid | input | 1 | Device offers a beat (device to memory) |
| dev_rx_data | input | 32 | Beat from the device |
| dev_rx_ready | output | 1 | Engine takes the offered beat |
| dev_tx_valid | output | 1 | Engine offers a beat (memory to device) |
| dev_tx_data | output | 32 | Beat to the device |
| dev_tx_ready | input | 1 | Device takes the beat |

## Verification
The bench builds the block with COMPL_BYTES = 32 and keeps the default LEN_W = 16. The smaller completion area is 8 words, so the bench can check every completion word. It can also check the untouched word just past the area, which shows the write count is exact. The full 16-bit length field lets the bench run a zero-length descriptor as a 65536-byte transfer. That transfer drives the wrap case of the length field and a long, unbroken count in both counters.

// File: rtl/sgdma_pkg.sv
// Package: shared constants and the engine state type for the
// scatter-gather DMA block. Assumes 32-bit registers and bus words.
package sgdma_pkg;
    localparam int WORD_W = 32;
    localparam int IDX_W  = 4;

    // Register word indexes
    localparam logic [IDX_W-1:0] RIX_TIMING  = 4'd0;
    localparam logic [IDX_W-1:0] RIX_LIST_LO = 4'd1;
    localparam logic [IDX_W-1:0] RIX_LIST_HI = 4'd2;
    localparam logic [IDX_W-1:0] RIX_ADDR_LO = 4'd3;
    localparam logic [IDX_W-1:0] RIX_ADDR_HI = 4'd4;
    localparam logic [IDX_W-1:0] RIX_DEV_CNT = 4'd5;
    localparam logic [IDX_W-1:0] RIX_MEM_CNT = 4'd6;
    localparam logic [IDX_W-1:0] RIX_CTRL    = 4'd7;
    localparam logic [IDX_W-1:0] RIX_DONE    = 4'd8;

    // Control/status bit positions
    localparam int CB_START  = 0;
    localparam int CB_STOP   = 1;
    localparam int CB_DIR    = 2;
    localparam int CB_ACTIVE = 3;
    localparam int CB_ERROR  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_RX,
        ST_WR,
        ST_RD,
        ST_TX,
        ST_DONE
    } eng_state_e;
endpackage

// File: rtl/sgdma_regs.sv
// Register bank: software-visible storage and control/status bits.
// Assumes a single-cycle write strobe and combinational read by index.
// The stop bit stays set until the engine acknowledges the halt.
module sgdma_regs
    import sgdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [IDX_W-1:0]  reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              eng_busy,
    input  logic              eng_halted,
    input  logic              eng_fault,
    input  logic [WORD_W-1:0] eng_cur_addr,
    input  logic [WORD_W-1:0] eng_dev_cnt,
    input  logic [WORD_W-1:0] eng_mem_cnt,
    output logic              start_pulse,
    output logic              stop_req,
    output logic              dir,
    output logic [WORD_W-1:0] list_ptr,
    output logic [WORD_W-1:0] done_addr
);
    logic [WORD_W-1:0] timing_q, list_lo_q, list_hi_q, addr_hi_q, done_q;
    logic stop_q, dir_q, err_q;
    logic wr_ctrl;

    // Decode a write to the control word
    assign wr_ctrl     = reg_wr && (reg_addr == RIX_CTRL);
    assign start_pulse = wr_ctrl && reg_wdata[CB_START] && !eng_busy;
    assign stop_req    = stop_q;
    assign dir         = dir_q;
    assign list_ptr    = list_lo_q;
    assign done_addr   = done_q;

    // Plain storage registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timing_q  <= '0;
            list_lo_q <= '0;
            list_hi_q <= '0;
            addr_hi_q <= '0;
            done_q    <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                RIX_TIMING:  timing_q  <= reg_wdata;
                RIX_LIST_LO: list_lo_q <= reg_wdata;
                RIX_LIST_HI: list_hi_q <= reg_wdata;
                RIX_ADDR_HI: addr_hi_q <= reg_wdata;
                RIX_DONE:    done_q    <= reg_wdata;
                default: ;
            endcase
        end
    end

    // Control bits: direction frozen while busy, stop held until halt, error sticky
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= 1'b0;
            dir_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (wr_ctrl && !eng_busy) dir_q <= reg_wdata[CB_DIR];
            if (wr_ctrl && reg_wdata[CB_STOP]) stop_q <= 1'b1;
            else if (eng_halted)               stop_q <= 1'b0;
            if (eng_fault)       err_q <= 1'b1;
            else if (eng_halted) err_q <= 1'b0;
        end
    end

    // Read multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RIX_TIMING:  reg_rdata = timing_q;
            RIX_LIST_LO: reg_rdata = list_lo_q;
            RIX_LIST_HI: reg_rdata = list_hi_q;
            RIX_ADDR_LO: reg_rdata = eng_cur_addr;
            RIX_ADDR_HI: reg_rdata = addr_hi_q;
            RIX_DEV_CNT: reg_rdata = eng_dev_cnt;
            RIX_MEM_CNT: reg_rdata = eng_mem_cnt;
            RIX_CTRL: begin
                reg_rdata[CB_STOP]   = stop_q;
                reg_rdata[CB_DIR]    = dir_q;
                reg_rdata[CB_ACTIVE] = eng_busy;
                reg_rdata[CB_ERROR]  = err_q;
            end
            RIX_DONE:    reg_rdata = done_q;
            default: ;
        endcase
    end

    // R3: direction cannot change while a transfer runs
    a_r3_dir_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |=> $stable(dir_q));
    // R10: a pending stop survives until the engine reports the halt
    a_r10_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        stop_q && !eng_halted |=> stop_q);
    // R11: error stays set until a halt completes
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q && !eng_halted |=> err_q);
endmodule

// File: rtl/sgdma_desc_unpack.sv
// Descriptor word unpacker: reorders a big-endian bus word into a value
// and extracts the end-of-list flag and the byte length of word 3.
// Assumes bus bits 7:0 carry the most significant byte. Length 0 maps
// to 2^LEN_W bytes.
module sgdma_desc_unpack
    import sgdma_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic [WORD_W-1:0] bus_word,
    output logic [WORD_W-1:0] be_word,
    output logic              eol,
    output logic [LEN_W:0]    len_bytes
);
    localparam int NBYTES = WORD_W / 8;

    // Byte reversal of the bus word
    for (genvar b = 0; b < NBYTES; b++) begin : g_swap
        assign be_word[8*b +: 8] = bus_word[8*(NBYTES-1-b) +: 8];
    end

    // Field extraction with zero-length wrap
    assign eol       = be_word[WORD_W-1];
    assign len_bytes = (be_word[LEN_W-1:0] == '0) ? {1'b1, {LEN_W{1'b0}}}
                                                  : {1'b0, be_word[LEN_W-1:0]};
endmodule

// File: rtl/sgdma_engine.sv
// Transfer engine: fetches descriptors, moves 32-bit beats between the
// device port and memory, keeps both byte counters and writes the
// completion area. Assumes one outstanding memory request, held until
// acknowledged, and word-aligned buffer addresses.
module sgdma_engine
    import sgdma_pkg::*;
#(
    parameter int LEN_W       = 16,
    parameter int COMPL_BYTES = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_pulse,
    input  logic              stop_req,
    input  logic              dir,
    input  logic [WORD_W-1:0] list_ptr,
    input  logic [WORD_W-1:0] done_addr,
    output logic              busy,
    output logic              halt_ack,
    output logic              fault,
    output logic [WORD_W-1:0] cur_addr,
    output logic [WORD_W-1:0] dev_cnt,
    output logic [WORD_W-1:0] mem_cnt,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              dev_rx_valid,
    input  logic [WORD_W-1:0] dev_rx_data,
    output logic              dev_rx_ready,
    output logic              dev_tx_valid,
    output logic [WORD_W-1:0] dev_tx_data,
    input  logic              dev_tx_ready
);
    localparam int REM_W       = LEN_W + 1;
    localparam int COMPL_WORDS = COMPL_BYTES / 4;
    localparam int CW_W        = (COMPL_WORDS > 1) ? $clog2(COMPL_WORDS) : 1;
    localparam logic [REM_W-1:0] BEAT_BYTES = REM_W'(4);

    eng_state_e state_q;
    logic [1:0]        widx_q;
    logic [WORD_W-1:0] cptr_q, baddr_q, dbuf_q, dcnt_q, mcnt_q;
    logic [REM_W-1:0]  rem_q;
    logic              eol_q;
    logic [CW_W-1:0]   cw_q;

    logic [WORD_W-1:0] dsc_word;
    logic              dsc_eol;
    logic [LEN_W:0]    dsc_len;
    logic [2:0]        step;
    logic [WORD_W-1:0] step_w;
    logic              last_beat, acc_ok;

    sgdma_desc_unpack #(.LEN_W(LEN_W)) u_unpack (
        .bus_word (mem_rdata),
        .be_word  (dsc_word),
        .eol      (dsc_eol),
        .len_bytes(dsc_len)
    );

    // Beat size and handshake helpers
    assign step      = (rem_q < BEAT_BYTES) ? rem_q[2:0] : 3'd4;
    assign step_w    = WORD_W'(step);
    assign last_beat = (rem_q <= BEAT_BYTES);
    assign acc_ok    = mem_ack && !mem_err;

    // Port outputs decoded from state
    assign busy         = (state_q != ST_IDLE);
    assign mem_req      = (state_q == ST_FETCH) || (state_q == ST_WR) ||
                          (state_q == ST_RD) || (state_q == ST_DONE);
    assign mem_we       = (state_q == ST_WR) || (state_q == ST_DONE);
    assign mem_wdata    = (state_q == ST_DONE) ? '1 : dbuf_q;
    assign dev_rx_ready = (state_q == ST_RX);
    assign dev_tx_valid = (state_q == ST_TX);
    assign dev_tx_data  = dbuf_q;
    assign halt_ack     = stop_req && (!mem_req || mem_ack);
    assign fault        = mem_req && mem_ack && mem_err;
    assign cur_addr     = baddr_q;
    assign dev_cnt      = dcnt_q;
    assign mem_cnt      = mcnt_q;

    // Memory address selection
    always_comb begin
        case (state_q)
            ST_FETCH:     mem_addr = cptr_q + {28'd0, widx_q, 2'b00};
            ST_WR, ST_RD: mem_addr = baddr_q;
            ST_DONE:      mem_addr = done_addr + (WORD_W'(cw_q) << 2);
            default:      mem_addr = '0;
        endcase
    end

    // Sequencer: descriptor walk, beat movement and completion writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            widx_q  <= '0;
            cptr_q  <= '0;
            baddr_q <= '0;
            dbuf_q  <= '0;
            dcnt_q  <= '0;
            mcnt_q  <= '0;
            rem_q   <= '0;
            eol_q   <= 1'b0;
            cw_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start_pulse && !stop_req) begin
                    state_q <= ST_FETCH;
                    widx_q  <= '0;
                    cptr_q  <= list_ptr;
                    dcnt_q  <= '0;
                    mcnt_q  <= '0;
                    cw_q    <= '0;
                end
                ST_FETCH: if (acc_ok) begin
                    widx_q <= widx_q + 2'd1;
                    if (widx_q == 2'd1) baddr_q <= dsc_word;
                    if (widx_q == 2'd3) begin
                        rem_q   <= dsc_len;
                        eol_q   <= dsc_eol;
                        cptr_q  <= cptr_q + 32'd16;
                        state_q <= dir ? ST_RX : ST_RD;
                    end
                end
                ST_RX: if (dev_rx_valid) begin
                    dbuf_q  <= dev_rx_data;
                    dcnt_q  <= dcnt_q + step_w;
                    state_q <= ST_WR;
                end
                ST_WR: if (acc_ok) begin
                    mcnt_q  <= mcnt_q + step_w;
                    baddr_q <= baddr_q + 32'd4;
                    rem_q   <= rem_q - REM_W'(step);
                    state_q <= !last_beat ? ST_RX : (eol_q ? ST_DONE : ST_FETCH);
                end
                ST_RD: if (acc_ok) begin
                    dbuf_q  <= mem_rdata;
                    mcnt_q  <= mcnt_q + step_w;
                    state_q <= ST_TX;
                end
                ST_TX: if (dev_tx_ready) begin
                    dcnt_q  <= dcnt_q + step_w;
                    baddr_q <= baddr_q + 32'd4;
                    rem_q   <= rem_q - REM_W'(step);
                    state_q <= !last_beat ? ST_RD : (eol_q ? ST_DONE : ST_FETCH);
                end
                ST_DONE: if (acc_ok) begin
                    cw_q <= cw_q + 1'b1;
                    if (cw_q == CW_W'(COMPL_WORDS - 1)) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
            if (busy && (halt_ack || fault)) state_q <= ST_IDLE;
        end
    end

    // R8: counters stay within one beat of each other
    a_r8_counts_close: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (dcnt_q <= mcnt_q + 32'd4) && (mcnt_q <= dcnt_q + 32'd4));
    // R8: counters agree once completion writes are under way
    a_r8_end_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |-> (dcnt_q == mcnt_q));
    // R5: data writes only happen in the device-to-memory direction
    a_r5_write_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WR) |-> dir);
    // R11: an error response ends all memory activity
    a_r11_quiet_after_err: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !mem_req && !busy);
    // R12: a pending request is held stable
    a_r12_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_wdata));
endmodule

// File: rtl/sgdma_ctrl.sv
// Top level of the scatter-gather DMA block: connects the register bank
// to the transfer engine. Assumes a single channel and 32-bit buses.
module sgdma_ctrl
    import sgdma_pkg::*;
#(
    parameter int LEN_W       = 16,
    parameter int COMPL_BYTES = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic        mem_err,
    input  logic [31:0] mem_rdata,
    input  logic        dev_rx_valid,
    input  logic [31:0] dev_rx_data,
    output logic        dev_rx_ready,
    output logic        dev_tx_valid,
    output logic [31:0] dev_tx_data,
    input  logic        dev_tx_ready
);
    logic              start_pulse, stop_req, dir, busy, halt_ack, fault;
    logic [WORD_W-1:0] list_ptr, done_addr, cur_addr, dev_cnt, mem_cnt;

    sgdma_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .eng_busy(busy), .eng_halted(halt_ack), .eng_fault(fault),
        .eng_cur_addr(cur_addr), .eng_dev_cnt(dev_cnt), .eng_mem_cnt(mem_cnt),
        .start_pulse(start_pulse), .stop_req(stop_req), .dir(dir),
        .list_ptr(list_ptr), .done_addr(done_addr)
    );

    sgdma_engine #(.LEN_W(LEN_W), .COMPL_BYTES(COMPL_BYTES)) u_engine (
        .clk(clk), .rst_n(rst_n),
        .start_pulse(start_pulse), .stop_req(stop_req), .dir(dir),
        .list_ptr(list_ptr), .done_addr(done_addr),
        .busy(busy), .halt_ack(halt_ack), .fault(fault),
        .cur_addr(cur_addr), .dev_cnt(dev_cnt), .mem_cnt(mem_cnt),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .mem_rdata(mem_rdata),
        .dev_rx_valid(dev_rx_valid), .dev_rx_data(dev_rx_data),
        .dev_rx_ready(dev_rx_ready),
        .dev_tx_valid(dev_tx_valid), .dev_tx_data(dev_tx_data),
        .dev_tx_ready(dev_tx_ready)
    );
endmodule

// File: tb/sgdma_ctrl_tb_top.sv
`timescale 1ns/1ps
// Directed bench for the scatter-gather DMA block: memory and device
// models, one task per scenario, results counted and summarised.
module sgdma_ctrl_tb_top;
    localparam int CB = 32;   // completion bytes used by this bench

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack, mem_err;
    logic [31:0] mem_rdata;
    logic        dev_rx_ready, dev_tx_valid;
    logic [31:0] dev_rx_data, dev_tx_data;
    logic        dev_rx_valid = 1'b1;
    logic        dev_tx_ready = 1'b1;

    sgdma_ctrl #(.LEN_W(16), .COMPL_BYTES(CB)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .mem_rdata(mem_rdata),
        .dev_rx_valid(dev_rx_valid), .dev_rx_data(dev_rx_data),
        .dev_rx_ready(dev_rx_ready),
        .dev_tx_valid(dev_tx_valid), .dev_tx_data(dev_tx_data),
        .dev_tx_ready(dev_tx_ready)
    );

    int n_chk = 0;
    int n_err = 0;

    // ---------------- memory model ----------------
    logic [31:0] mem_model [0:32767];
    logic        hold_ack = 1'b0;
    logic        err_en = 1'b0;
    logic [31:0] err_addr = '0;
    logic        pl_we = 1'b0;
    logic [31:0] pl_addr = '0, pl_data = '0;
    logic        bk_clr = 1'b0;
    logic [31:0] done_lo = '0;
    int          done_wr_cnt;
    logic        seen_done, order_bad;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32768; i++) mem_model[i] <= '0;
            mem_ack <= 1'b0; mem_err <= 1'b0; mem_rdata <= '0;
            done_wr_cnt <= 0; seen_done <= 1'b0; order_bad <= 1'b0;
        end else begin
            if (pl_we) mem_model[pl_addr[16:2]] <= pl_data;
            if (bk_clr) begin
                done_wr_cnt <= 0; seen_done <= 1'b0; order_bad <= 1'b0;
            end
            if (mem_req && !mem_ack && !hold_ack) begin
                mem_ack <= 1'b1;
                if (err_en && mem_addr == err_addr) mem_err <= 1'b1;
                else begin
                    mem_err <= 1'b0;
                    if (mem_we) begin
                        mem_model[mem_addr[16:2]] <= mem_wdata;
                        if (mem_addr >= done_lo && mem_addr < done_lo + CB) begin
                            done_wr_cnt <= done_wr_cnt + 1;
                            seen_done <= 1'b1;
                        end else if (seen_done) order_bad <= 1'b1;
                    end else mem_rdata <= mem_model[mem_addr[16:2]];
                end
            end else begin
                mem_ack <= 1'b0; mem_err <= 1'b0;
            end
        end
    end

    // ---------------- device models ----------------
    logic [15:0] rx_idx;
    int          tx_idx;
    logic [31:0] tx_log [0:15];
    logic        dev_clr = 1'b0;

    function automatic logic [31:0] rx_pat(input logic [15:0] i);
        return {16'hC0DE, i};
    endfunction
    assign dev_rx_data = rx_pat(rx_idx);

    always @(posedge clk) begin
        if (!rst_n || dev_clr) begin
            rx_idx <= '0; tx_idx <= 0;
        end else begin
            if (dev_rx_valid && dev_rx_ready) rx_idx <= rx_idx + 16'd1;
            if (dev_tx_valid && dev_tx_ready) begin
                if (tx_idx < 16) tx_log[tx_idx] <= dev_tx_data;
                tx_idx <= tx_idx + 1;
            end
        end
    end

    // ---------------- helpers ----------------
    function automatic logic [31:0] bswap(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] idx, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = idx; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] idx, output logic [31:0] d);
        @(negedge clk); reg_addr = idx; #1; d = reg_rdata;
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk); pl_we = 1'b1; pl_addr = a; pl_data = d;
        @(negedge clk); pl_we = 1'b0;
    endtask

    task automatic put_desc(input logic [31:0] at, input logic [31:0] buf_a,
                            input logic eol, input logic [15:0] len);
        poke(at,      32'h0);
        poke(at + 4,  bswap(buf_a));
        poke(at + 8,  32'h0);
        poke(at + 12, bswap({eol, 15'h0, len}));
    endtask

    task automatic prep(input logic [31:0] list, input logic [31:0] done);
        @(negedge clk); bk_clr = 1'b1; dev_clr = 1'b1; done_lo = done;
        @(negedge clk); bk_clr = 1'b0; dev_clr = 1'b0;
        reg_write(4'd1, list);
        reg_write(4'd8, done);
    endtask

    task automatic wait_idle(input int max);
        logic [31:0] v;
        for (int i = 0; i < max; i++) begin
            reg_read(4'd7, v);
            if (!v[3]) return;
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        logic [31:0] v;
        reg_read(4'd7, v); check("R2 reset ctrl", v, 32'h0);
        reg_read(4'd5, v); check("R8 reset dev count", v, 32'h0);
        reg_read(4'd6, v); check("R8 reset mem count", v, 32'h0);
        check("R10 reset no request", {31'h0, mem_req}, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        reg_write(4'd0, 32'h1234_5678); reg_read(4'd0, v); check("R1 timing", v, 32'h1234_5678);
        reg_write(4'd2, 32'hAAAA_0001); reg_read(4'd2, v); check("R1 list high", v, 32'hAAAA_0001);
        reg_write(4'd4, 32'h5555_0002); reg_read(4'd4, v); check("R1 addr high", v, 32'h5555_0002);
        reg_write(4'd8, 32'h0000_4000); reg_read(4'd8, v); check("R1 completion addr", v, 32'h0000_4000);
        reg_write(4'd3, 32'hDEAD_BEEF); reg_read(4'd3, v); check("R1 addr low ignores write", v, 32'h0);
        reg_write(4'd5, 32'h77);        reg_read(4'd5, v); check("R1 dev count read-only", v, 32'h0);
        reg_read(4'd12, v); check("R1 unused index", v, 32'h0);
    endtask

    task automatic t_rx();
        logic [31:0] v;
        put_desc(32'h1000, 32'h2000, 1'b0, 16'd12);
        put_desc(32'h1010, 32'h3000, 1'b1, 16'd6);
        prep(32'h1000, 32'h4000);
        reg_read(4'd7, v);
        reg_write(4'd7, v | 32'h5);
        reg_read(4'd7, v); check("R2 active and dir while running", v & 32'h1D, 32'h0C);
        wait_idle(2000);
        reg_read(4'd7, v); check("R9 active clears", v, 32'h4);
        for (int i = 0; i < 3; i++)
            check("R5 first buffer data", mem_model[(32'h2000 >> 2) + i], rx_pat(16'(i)));
        check("R5 second buffer word0", mem_model[32'h3000 >> 2], rx_pat(16'd3));
        check("R4 second descriptor short beat", mem_model[(32'h3000 >> 2) + 1], rx_pat(16'd4));
        reg_read(4'd5, v); check("R8 dev count", v, 32'd18);
        reg_read(4'd6, v); check("R8 mem count", v, 32'd18);
        reg_read(4'd3, v); check("R1 current address", v, 32'h3008);
        for (int i = 0; i < CB / 4; i++)
            check("R9 completion word", mem_model[(32'h4000 >> 2) + i], 32'hFFFF_FFFF);
        check("R9 past completion area", mem_model[(32'h4000 + CB) >> 2], 32'h0);
        check("R9 completion write count", 32'(done_wr_cnt), 32'(CB / 4));
        check("R9 no data after completion", {31'h0, order_bad}, 32'h0);
    endtask

    task automatic t_tx();
        logic [31:0] v;
        poke(32'h5000, 32'hA1B2_C3D4);
        poke(32'h5004, 32'h0102_0304);
        put_desc(32'h1100, 32'h5000, 1'b1, 16'd8);
        prep(32'h1100, 32'h4040);
        reg_write(4'd7, 32'h1);
        wait_idle(2000);
        check("R6 tx beat count", 32'(tx_idx), 32'd2);
        check("R6 tx beat 0", tx_log[0], 32'hA1B2_C3D4);
        check("R6 tx beat 1", tx_log[1], 32'h0102_0304);
        reg_read(4'd5, v); check("R8 tx dev count", v, 32'd8);
        reg_read(4'd6, v); check("R8 tx mem count", v, 32'd8);
        check("R9 tx completion word", mem_model[(32'h4040 >> 2) + 7], 32'hFFFF_FFFF);
    endtask

    task automatic t_zero_len();
        logic [31:0] v;
        put_desc(32'h1200, 32'h8000, 1'b1, 16'd0);
        prep(32'h1200, 32'h4080);
        reg_write(4'd7, 32'h5);
        wait_idle(70000);
        reg_read(4'd5, v); check("R7 full-length dev count", v, 32'd65536);
        reg_read(4'd6, v); check("R7 full-length mem count", v, 32'd65536);
        check("R7 last word", mem_model[(32'h8000 + 32'hFFFC) >> 2], rx_pat(16'd16383));
        check("R7 word past buffer", mem_model[32'h18000 >> 2], 32'h0);
    endtask

    task automatic t_start_stop();
        logic [31:0] v;
        put_desc(32'h1300, 32'h6000, 1'b1, 16'd16);
        prep(32'h1300, 32'h40C0);
        hold_ack = 1'b1;
        reg_write(4'd7, 32'h5);
        reg_write(4'd7, 32'h1);
        reg_read(4'd7, v); check("R3 start while active keeps dir/active", v, 32'hC);
        reg_read(4'd5, v); check("R3 counters untouched", v, 32'h0);
        reg_write(4'd7, 32'h2);
        reg_read(4'd7, v); check("R10 stop pending", v, 32'hE);
        repeat (3) @(negedge clk);
        reg_read(4'd7, v); check("R10 stop still pending", v, 32'hE);
        hold_ack = 1'b0;
        repeat (4) @(negedge clk);
        reg_read(4'd7, v); check("R10 halted", v, 32'h4);
        check("R10 no request after halt", {31'h0, mem_req}, 32'h0);
        check("R10 no completion write", 32'(done_wr_cnt), 32'h0);
    endtask

    task automatic t_error();
        logic [31:0] v;
        put_desc(32'h1400, 32'h7000, 1'b1, 16'd16);
        prep(32'h1400, 32'h4100);
        err_addr = 32'h7004; err_en = 1'b1;
        reg_write(4'd7, 32'h5);
        wait_idle(2000);
        reg_read(4'd7, v); check("R11 error set, active clear", v, 32'h14);
        check("R11 failed word not written", mem_model[32'h7004 >> 2], 32'h0);
        reg_read(4'd6, v); check("R11 mem count stops", v, 32'd4);
        check("R11 no completion write", 32'(done_wr_cnt), 32'h0);
        check("R11 no request after error", {31'h0, mem_req}, 32'h0);
        repeat (5) @(negedge clk);
        reg_read(4'd7, v); check("R11 error remains", v & 32'h10, 32'h10);
        err_en = 1'b0;
        reg_write(4'd7, 32'h2);
        repeat (2) @(negedge clk);
        reg_read(4'd7, v); check("R11 error cleared by stop", v, 32'h0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_rx();
        t_tx();
        t_zero_len();
        t_start_stop();
        t_error();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule